// File: doc/BRIEF.md
# Retirement Verification Checker

This block sits between a speculative execution core and the architected register file, and retires every instruction the core finishes. The core does all other work. Nothing reaches architected state until this block has verified it. Each entry from the core carries an operation code, a destination index, two source indices, the two operand values the core used and the result the core produced.

The block runs two checks in parallel on every entry. The computation check recomputes the result from the core's operands with a small local ALU and compares it with the core's result. The communication check compares the core's operands with the values held in architected storage. If the instruction directly ahead is writing a source register, the value it is writing is forwarded into that comparison. An entry that passes both checks commits the core's result. An entry that fails either check commits a value recomputed from the architected operands. The block then asks the core to flush and restart, and it discards core entries until the core signals that it has resumed. A no-progress watchdog also raises the restart request when the core keeps reporting outstanding work but nothing retires.

Control is a three-state machine. In `ST_RUN` the block accepts, checks and commits. In `ST_FLUSH` it drives the restart pulse for one cycle. In `ST_DROP` it discards entries while waiting for the core. The transitions are: `ST_RUN`→`ST_FLUSH` on a check failure or on watchdog expiry; `ST_FLUSH`→`ST_DROP` always; `ST_DROP`→`ST_RUN` when `core_resume` is sampled high.

Top module: `commit_checker`

## Requirements
- R1: An entry accepted at a clock edge (`in_valid` high; `in_ready` is high in every state) while in `ST_RUN` shows on `commit_valid`, `commit_rd` and `commit_data` for exactly one cycle, in the cycle after that edge. An entry that passes both checks commits the core's result unchanged and leaves `check_fail` low.
- R2: If the local ALU result for the core's operands differs from `in_res`, `check_fail` is high together with `commit_valid`.
- R3: If `in_opa` differs from the architected value of `in_rs1`, the entry fails. The same applies when `in_opb` differs from the architected value of `in_rs2`, except for the immediate operation (code 6), where `in_opb` is an immediate and is not compared.
- R4: A failing entry commits the ALU result computed from the architected operands, with the immediate taken from `in_opb` for code 6. The cycle after a failing commit carries no commit.
- R5: When a source index equals the destination of the entry committing in the same cycle, the checker uses the value being committed, not the old register contents.
- R6: Register 0 reads as zero at all times. A commit to it appears on the commit port but leaves it zero.
- R7: Operation codes: 0 add, 1 subtract, 2 AND, 3 OR, 4 XOR, 5 signed set-less-than (result 1 or 0), 6 immediate (result is `in_opb`), 7 result zero.
- R8: After a failing commit, `restart` is high for exactly one cycle, in the next cycle. Entries offered from the failing cycle up to and including the cycle in which `core_resume` is sampled are discarded. `core_resume` is ignored during the restart cycle.
- R9: In `ST_RUN`, each cycle with `core_busy` high and no commit advances a counter. A commit clears it. Cycles with `core_busy` low hold it. On the 64th counted cycle the block enters `ST_FLUSH`, so `restart` rises in the next cycle and discarding follows as in R8.
- R10: During and right after reset, `commit_valid`, `check_fail` and `restart` are low, and every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Core offers a completed instruction |
| in_ready | output | 1 | Checker takes an entry this cycle |
| in_op | input | 3 | Operation code (R7) |
| in_rd | input | 4 | Destination register index |
| in_rs1 | input | 4 | First source index |
| in_rs2 | input | 4 | Second source index |
| in_opa | input | 32 | First operand value the core used |
| in_opb | input | 32 | Second operand or immediate the core used |
| in_res | input | 32 | Result the core produced |
| core_busy | input | 1 | Core has work outstanding |
| core_resume | input | 1 | Core has restarted and sends valid entries again |
| commit_valid | output | 1 | A register write retires this cycle |
| commit_rd | output | 4 | Retiring destination index |
| commit_data | output | 32 | Retiring verified or recomputed value |
| check_fail | output | 1 | The retiring entry failed a check |
| restart | output | 1 | One-cycle flush-and-restart request to the core |

## Verification
Every ALU operation is first run with honest operands, including signed compares in both directions, so the recompute path alone is exercised. Three corruptions follow: a wrong result, a wrong first operand and a wrong second operand. Each one is separated from the others by which value the fix-up commit must carry. Chains of back-to-back dependent entries show whether forwarding supplies the in-flight value, since a stale read turns a correct entry into a failure. Writes to register 0, entries offered while discarding, and busy intervals that do or do not reach 64 counted cycles probe the zero register, the drop window, and the rule that commits clear the watchdog and idle cycles hold it.

// File: rtl/chk_pkg.sv
package chk_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_SLT = 3'd5,
        OP_IMM = 3'd6,
        OP_NUL = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_FLUSH = 2'd1,
        ST_DROP  = 2'd2
    } st_e;

endpackage

// File: rtl/chk_alu.sv
module chk_alu
    import chk_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);

    always_comb begin
        unique case (op)
            OP_ADD: y = a + b;
            OP_SUB: y = a - b;
            OP_AND: y = a & b;
            OP_OR:  y = a | b;
            OP_XOR: y = a ^ b;
            OP_SLT: y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            OP_IMM: y = b;
            OP_NUL: y = '0;
        endcase
    end

endmodule

// File: rtl/chk_regfile.sv
module chk_regfile #(
    parameter int W    = 32,
    parameter int NREG = 16,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    logic [W-1:0] mem [NREG];

    // index 0 is never written, so it holds its reset value of zero
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && (waddr != '0)) begin
            mem[waddr] <= wdata;
        end
    end

    generate
        for (genvar g = 0; g < NRD; g++) begin : g_rd
            assign rdata[g] = (raddr[g] == '0) ? '0 : mem[raddr[g]];
        end
    endgenerate

endmodule

// File: rtl/chk_watchdog.sv
module chk_watchdog #(
    parameter int TIMEOUT = 64,
    localparam int CW     = $clog2(TIMEOUT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic expire
);

    logic [CW-1:0] cnt;

    assign expire = tick && (cnt == CW'(TIMEOUT - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (clr || expire)  cnt <= '0;
        else if (tick)           cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/commit_checker.sv
module commit_checker
    import chk_pkg::*;
#(
    parameter int W       = 32,
    parameter int NREG    = 16,
    parameter int TIMEOUT = 64,
    localparam int RW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [2:0]    in_op,
    input  logic [RW-1:0] in_rd,
    input  logic [RW-1:0] in_rs1,
    input  logic [RW-1:0] in_rs2,
    input  logic [W-1:0]  in_opa,
    input  logic [W-1:0]  in_opb,
    input  logic [W-1:0]  in_res,
    input  logic          core_busy,
    input  logic          core_resume,
    output logic          commit_valid,
    output logic [RW-1:0] commit_rd,
    output logic [W-1:0]  commit_data,
    output logic          check_fail,
    output logic          restart
);

    localparam int NSRC = 2;

    st_e state, state_nx;

    // check stage: the entry retiring this cycle
    logic          s_valid;
    logic [2:0]    s_op;
    logic [RW-1:0] s_rd;
    logic [W-1:0]  s_opa, s_opb, s_res;
    logic [W-1:0]  s_arch_a, s_arch_b;

    logic [NSRC-1:0][RW-1:0] rd_idx;
    logic [NSRC-1:0][W-1:0]  rf_val;
    logic [NSRC-1:0][W-1:0]  src_val;

    logic [W-1:0] y_core, y_fix, fix_b;
    logic         comp_ok, comm_ok, fail;
    logic         wd_tick, wd_clr, wd_expire;
    logic         accept, go_flush, load;

    // ---------------- architected storage and forwarding ----------------
    assign rd_idx = {in_rs2, in_rs1};

    chk_regfile #(.W(W), .NREG(NREG), .NRD(NSRC)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (commit_valid),
        .waddr (commit_rd),
        .wdata (commit_data),
        .raddr (rd_idx),
        .rdata (rf_val)
    );

    generate
        for (genvar g = 0; g < NSRC; g++) begin : g_fwd
            assign src_val[g] = (s_valid && (s_rd != '0) && (s_rd == rd_idx[g]))
                              ? commit_data : rf_val[g];
        end
    endgenerate

    // ---------------- recompute and compare ----------------
    chk_alu #(.W(W)) u_alu_chk (
        .op (op_e'(s_op)),
        .a  (s_opa),
        .b  (s_opb),
        .y  (y_core)
    );

    assign fix_b = (s_op == OP_IMM) ? s_opb : s_arch_b;

    chk_alu #(.W(W)) u_alu_fix (
        .op (op_e'(s_op)),
        .a  (s_arch_a),
        .b  (fix_b),
        .y  (y_fix)
    );

    assign comp_ok = (y_core == s_res);
    assign comm_ok = (s_opa == s_arch_a) && ((s_op == OP_IMM) || (s_opb == s_arch_b));
    assign fail    = s_valid && !(comp_ok && comm_ok);

    assign commit_valid = s_valid;
    assign commit_rd    = s_rd;
    assign commit_data  = fail ? y_fix : s_res;
    assign check_fail   = fail;

    // ---------------- progress watchdog ----------------
    assign wd_tick = (state == ST_RUN) && core_busy && !s_valid;
    assign wd_clr  = s_valid || (state != ST_RUN);

    chk_watchdog #(.TIMEOUT(TIMEOUT)) u_wd (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wd_clr),
        .tick   (wd_tick),
        .expire (wd_expire)
    );

    // ---------------- control ----------------
    assign accept   = in_valid && in_ready;
    assign go_flush = (state == ST_RUN) && (fail || wd_expire);
    assign load     = accept && (state == ST_RUN) && !go_flush;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   if (go_flush)    state_nx = ST_FLUSH;
            ST_FLUSH:                  state_nx = ST_DROP;
            ST_DROP:  if (core_resume) state_nx = ST_RUN;
            default:                   state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        unique case (state)
            ST_RUN:   begin restart = 1'b0; in_ready = 1'b1; end
            ST_FLUSH: begin restart = 1'b1; in_ready = 1'b1; end
            ST_DROP:  begin restart = 1'b0; in_ready = 1'b1; end
            default:  begin restart = 1'b0; in_ready = 1'b1; end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_valid  <= 1'b0;
            s_op     <= '0;
            s_rd     <= '0;
            s_opa    <= '0;
            s_opb    <= '0;
            s_res    <= '0;
            s_arch_a <= '0;
            s_arch_b <= '0;
        end else begin
            s_valid <= load;
            if (load) begin
                s_op     <= in_op;
                s_rd     <= in_rd;
                s_opa    <= in_opa;
                s_opb    <= in_opb;
                s_res    <= in_res;
                s_arch_a <= src_val[0];
                s_arch_b <= src_val[1];
            end
        end
    end

endmodule

// File: rtl/commit_checker_sva.sv
module commit_checker_sva #(
    parameter int TIMEOUT = 64,
    localparam int QW     = $clog2(TIMEOUT + 1) + 1
) (
    input logic clk,
    input logic rst_n,
    input logic core_busy,
    input logic core_resume,
    input logic commit_valid,
    input logic check_fail,
    input logic restart
);

    logic          dropping;
    logic [QW-1:0] idle_q;

    // independent view of the drop window, taken from the ports only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        dropping <= 1'b0;
        else if (restart)                  dropping <= 1'b1;
        else if (dropping && core_resume)  dropping <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   idle_q <= '0;
        else if (restart || commit_valid || dropping) idle_q <= '0;
        else if (core_busy)                           idle_q <= idle_q + 1'b1;
    end

    AST_FAIL_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        check_fail |-> commit_valid);                                   // R2
    AST_FAIL_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_valid && check_fail) |=> restart);                      // R8
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart);                                          // R8
    AST_QUIET_AFTER_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !commit_valid);                                     // R8
    AST_NO_COMMIT_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
        check_fail |=> !commit_valid);                                  // R4
    AST_NO_COMMIT_WHILE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        dropping |-> !commit_valid);                                    // R8
    AST_WDOG_FIRES: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_q == QW'(TIMEOUT)) |-> restart);                          // R9
    AST_WDOG_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !$past(check_fail)) |-> (idle_q == QW'(TIMEOUT)));   // R9

endmodule

bind commit_checker commit_checker_sva #(.TIMEOUT(TIMEOUT)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .core_busy    (core_busy),
    .core_resume  (core_resume),
    .commit_valid (commit_valid),
    .check_fail   (check_fail),
    .restart      (restart)
);

// File: tb/commit_checker_bench.sv
module commit_checker_bench;

    localparam int WD = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [2:0]  in_op = '0;
    logic [3:0]  in_rd = '0, in_rs1 = '0, in_rs2 = '0;
    logic [31:0] in_opa = '0, in_opb = '0, in_res = '0;
    logic        core_busy = 1'b0;
    logic        core_resume = 1'b0;
    logic        commit_valid;
    logic [3:0]  commit_rd;
    logic [31:0] commit_data;
    logic        check_fail;
    logic        restart;

    always #2 clk = ~clk;

    commit_checker u_commit_checker (
        .clk (clk), .rst_n (rst_n),
        .in_valid (in_valid), .in_ready (in_ready),
        .in_op (in_op), .in_rd (in_rd), .in_rs1 (in_rs1), .in_rs2 (in_rs2),
        .in_opa (in_opa), .in_opb (in_opb), .in_res (in_res),
        .core_busy (core_busy), .core_resume (core_resume),
        .commit_valid (commit_valid), .commit_rd (commit_rd),
        .commit_data (commit_data), .check_fail (check_fail),
        .restart (restart)
    );

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string phase = "R10 reset";

    function automatic logic [31:0] ref_alu(int op, logic [31:0] a, logic [31:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
            6: return b;
            default: return 32'd0;
        endcase
    endfunction

    // ---------------- reference model ----------------
    logic [31:0] arch [16];
    logic [31:0] core_rf [16];
    bit          p_v = 0;
    int          p_op = 0, p_rd = 0, p_rs1 = 0, p_rs2 = 0;
    logic [31:0] p_a = 0, p_b = 0, p_res = 0;
    int          mode = 0;   // 0 run, 1 restart cycle, 2 discarding
    int          wd = 0;
    int          restarts_seen = 0;

    initial for (int i = 0; i < 16; i++) begin arch[i] = 0; core_rf[i] = 0; end

    task automatic model_eval(output bit f, output logic [31:0] d);
        logic [31:0] aa, ab, fb;
        aa = (p_rs1 == 0) ? 32'd0 : arch[p_rs1];
        ab = (p_rs2 == 0) ? 32'd0 : arch[p_rs2];
        f  = (ref_alu(p_op, p_a, p_b) != p_res) || (p_a != aa) || ((p_op != 6) && (p_b != ab));
        fb = (p_op == 6) ? p_b : ab;
        d  = f ? ref_alu(p_op, aa, fb) : p_res;
    endtask

    always @(posedge clk) begin
        bit          f, fire;
        logic [31:0] d;
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) arch[i] = 0;
            p_v = 0; mode = 0; wd = 0;
        end else begin
            fire = 0;
            model_eval(f, d);
            if (mode == 0) begin
                if (p_v) begin
                    wd = 0;
                    if (f) fire = 1;
                end else if (core_busy) begin
                    if (wd == WD - 1) begin fire = 1; wd = 0; end
                    else wd = wd + 1;
                end
            end else wd = 0;
            if (p_v && p_rd != 0) arch[p_rd] = d;
            if (in_valid && mode == 0 && !fire) begin
                p_v = 1; p_op = int'(in_op); p_rd = int'(in_rd);
                p_rs1 = int'(in_rs1); p_rs2 = int'(in_rs2);
                p_a = in_opa; p_b = in_opb; p_res = in_res;
            end else p_v = 0;
            if (mode == 0 && fire)               mode = 1;
            else if (mode == 1)                  mode = 2;
            else if (mode == 2 && core_resume)   mode = 0;
        end
    end

    task automatic chk(bit ok, string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %h expected %h", phase, what, got, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) if (!done) begin
        bit          f;
        logic [31:0] d;
        model_eval(f, d);
        chk(commit_valid == p_v, "commit_valid", 32'(commit_valid), 32'(p_v));
        chk(restart == (mode == 1), "restart", 32'(restart), 32'(mode == 1));
        chk(in_ready == 1'b1, "in_ready", 32'(in_ready), 32'd1);
        if (p_v) begin
            chk(int'(commit_rd) == p_rd, "commit_rd", 32'(commit_rd), 32'(p_rd));
            chk(commit_data == d, "commit_data", commit_data, d);
            chk(check_fail == f, "check_fail", 32'(check_fail), 32'(f));
        end else begin
            chk(check_fail == 1'b0, "check_fail idle", 32'(check_fail), 32'd0);
        end
        if (restart) restarts_seen++;
    end

    // ---------------- stimulus ----------------
    // kind: 0 honest, 1 wrong result, 2 wrong first operand, 3 wrong second operand
    task automatic issue(int op, int rd, int rs1, int rs2, logic [31:0] imm, int kind);
        logic [31:0] a, b, r;
        @(negedge clk);
        a = (rs1 == 0) ? 32'd0 : core_rf[rs1];
        b = (op == 6) ? imm : ((rs2 == 0) ? 32'd0 : core_rf[rs2]);
        r = ref_alu(op, a, b);
        if (kind == 0 && rd != 0) core_rf[rd] = r;
        if (kind == 1) r = r ^ 32'h0000_0100;
        if (kind == 2) begin a = a ^ 32'h1; r = ref_alu(op, a, b); end
        if (kind == 3) begin b = b ^ 32'h8000_0000; r = ref_alu(op, a, b); end
        in_valid = 1; in_op = 3'(op); in_rd = 4'(rd); in_rs1 = 4'(rs1); in_rs2 = 4'(rs2);
        in_opa = a; in_opb = b; in_res = r;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 0;
            core_resume = 0;
        end
    endtask

    task automatic resume_core();
        @(negedge clk);
        in_valid = 0;
        core_resume = 1;
        @(negedge clk);
        core_resume = 0;
        idle(2);
        for (int i = 0; i < 16; i++) core_rf[i] = arch[i];
    endtask

    task automatic fault_case(int op, int rd, int rs1, int rs2, logic [31:0] imm, int kind);
        issue(op, rd, rs1, rs2, imm, kind);
        issue(0, 7, 1, 1, 0, 0);   // discarded (R8)
        issue(6, 8, 0, 0, 32'h77, 0);
        idle(1);
        issue(6, 9, 0, 0, 32'h99, 0);
        idle(2);
        resume_core();
    endtask

    initial begin
        idle(3);
        rst_n = 1;
        idle(2);

        phase = "R7 R1 alu ops";
        issue(6, 1, 0, 0, 32'd100, 0);
        issue(6, 2, 0, 0, 32'hFFFF_FFF9, 0);
        issue(6, 3, 0, 0, 32'h0F0F_00FF, 0);
        issue(0, 4, 1, 2, 0, 0);
        issue(1, 5, 1, 2, 0, 0);
        issue(2, 6, 2, 3, 0, 0);
        issue(3, 7, 1, 3, 0, 0);
        issue(4, 8, 2, 3, 0, 0);
        issue(5, 9, 2, 1, 0, 0);
        issue(5, 10, 1, 2, 0, 0);
        issue(7, 12, 1, 2, 0, 0);
        idle(2);

        phase = "R5 bypass chain";
        issue(0, 11, 4, 1, 0, 0);
        issue(0, 11, 11, 11, 0, 0);
        issue(4, 12, 11, 2, 0, 0);
        issue(1, 13, 3, 12, 0, 0);
        idle(3);

        phase = "R6 zero register";
        issue(6, 0, 0, 0, 32'd55, 0);
        issue(0, 13, 0, 1, 0, 0);
        issue(3, 14, 0, 0, 0, 0);
        idle(3);

        phase = "R2 R8 wrong result";
        core_busy = 1;
        fault_case(0, 14, 1, 3, 0, 1);
        phase = "R4 fixup readback";
        issue(0, 15, 14, 0, 0, 0);
        idle(2);

        phase = "R3 R8 wrong first operand";
        fault_case(1, 5, 4, 3, 0, 2);
        phase = "R3 wrong second operand";
        fault_case(4, 6, 1, 2, 0, 3);
        phase = "R3 immediate skips second operand";
        issue(6, 2, 0, 5, 32'h1234_5678, 0);
        phase = "R5 R3 forwarded operand";
        issue(0, 3, 2, 2, 0, 0);
        idle(3);

        phase = "R9 watchdog";
        restarts_seen = 0;
        core_busy = 1;
        idle(70);
        resume_core();
        idle(40);
        issue(0, 4, 1, 1, 0, 0);
        idle(40);
        core_busy = 0;
        idle(60);
        core_busy = 1;
        idle(30);
        core_busy = 0;
        idle(2);
        checks++;
        if (restarts_seen != 2) begin
            errors++;
            $display("FAIL R9 restart count got %0d expected %0d", restarts_seen, 2);
        end
        resume_core();
        idle(3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete got %0d expected %0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule